// File: doc/BRIEF.md
# Steering Target Resolver

This block answers one question for a replicated-register access path: given a register offset, which group and instance must a read be steered to so that it reaches a unit that is present and powered, rather than one that is fused off? Each of four steering classes owns a programmable table of inclusive address ranges. The offset is compared against all tables in parallel. The classes are then examined in a fixed priority order, and the first class whose table holds the offset decides how the group and instance IDs are formed from the fuse masks. An offset that no table claims gets the configured default IDs.

Requests arrive on a valid/ready stream that carries the offset. Results leave on a second valid/ready stream one clock later, with the group, the instance, a class code and a flag for an empty mask. The single output register also serves as the only buffer. The upstream side sees `in_ready` high whenever the output register is empty, or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. Tables, enables, fuse masks and default IDs are plain configuration inputs and are treated as static while requests are in flight.

Top module: `steer_resolver`

## Requirements
- R1: An offset hits a table entry when the entry's valid bit is set and start <= offset <= end, with both bounds included; start-1 and end+1 do not hit.
- R2: Classes are examined in the order L3-bank (code 0), memory-slice (code 1), LNCF (code 2), instance-zero (code 3). The lowest-coded class that hits wins, even if other tables also contain the offset.
- R3: A class whose enable bit `cfg_class_en[code]` is 0 never matches. An entry whose valid bit is 0 never hits.
- R4: For class 0, the group is 0 and the instance is the index of the lowest set bit of the available-bank mask. That mask is the bitwise inverse of `cfg_l3_dis`.
- R5: For class 1, the group is the index of the lowest set bit of the slice mask and the instance is 0.
- R6: For class 2, the group is twice the lowest set slice index and the instance is 0.
- R7: For class 3, the group and the instance are both 0.
- R8: When no class matches, the class code is 4 and the outputs are `cfg_dflt_group` and `cfg_dflt_inst`.
- R9: Bit s of the slice mask is set when any of sub-slice bits `cfg_ss_mask[s*SS_PER_SLICE +: SS_PER_SLICE]` is set, or when `cfg_slice_mem_en[s]` is set.
- R10: If the winning class is 0 and the available-bank mask is all zero, `out_mask_empty` is 1 and both IDs are 0. The same holds if the winning class is 1 or 2 and the slice mask is all zero. In every other case `out_mask_empty` is 0.
- R11: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high from the next cycle on. While `out_valid` is high and `out_ready` is low, the outputs stay stable and `in_ready` is low.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offset is valid |
| in_ready | output | 1 | Block can accept a request |
| in_offset | input | ADDR_W | Register offset to resolve |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_group | output | GROUP_W | Resolved group ID |
| out_inst | output | INST_W | Resolved instance ID |
| out_class | output | 3 | Winning class code, or 4 for the default |
| out_mask_empty | output | 1 | Winning class had an all-zero mask |
| cfg_ss_mask | input | NSLICE*SS_PER_SLICE | Enabled sub-slices, grouped by slice |
| cfg_slice_mem_en | input | NSLICE | Per-slice memory enable fuses |
| cfg_l3_dis | input | L3_BANKS | L3-bank disable fuses |
| cfg_class_en | input | 4 | Per-class table enable |
| cfg_tbl_start | input | 4*NRANGE*ADDR_W | Range starts, entry e of class c at slot c*NRANGE+e |
| cfg_tbl_end | input | 4*NRANGE*ADDR_W | Range ends, same slots as the starts |
| cfg_tbl_valid | input | 4*NRANGE | Per-entry valid bits |
| cfg_dflt_group | input | GROUP_W | Default group ID |
| cfg_dflt_inst | input | INST_W | Default instance ID |

## Verification
A wrong comparator bound or a swapped priority shows up as a wrong class code, and wrong IDs, on the very response that follows the offset in question. A sweep across every offset of a small window around the range edges therefore exposes it within one transaction. A faulty lowest-set-bit search or slice-mask merge shows as a wrong group or instance for every offset of the affected class, once a fuse pattern puts the lowest set bit away from index 0. A broken output register shows as a changed or lost result during a back-pressure stall, in the cycle the stall ends.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NCLASS = 4;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_L3BANK  = 3'd0,
    CLS_MSLICE  = 3'd1,
    CLS_LNCF    = 3'd2,
    CLS_INST0   = 3'd3,
    CLS_DEFAULT = 3'd4
  } steer_class_e;
endpackage

// File: rtl/steer_lowbit.sv
module steer_lowbit #(
  parameter int W     = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx  = IDX_W'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/steer_range_match.sv
module steer_range_match #(
  parameter int ADDR_W = 24,
  parameter int NRANGE = 12
) (
  input  logic [ADDR_W-1:0]        offset,
  input  logic [NRANGE*ADDR_W-1:0] starts,
  input  logic [NRANGE*ADDR_W-1:0] ends,
  input  logic [NRANGE-1:0]        valids,
  input  logic                     enable,
  output logic                     hit
);
  logic [NRANGE-1:0] entry_hit;

  for (genvar e = 0; e < NRANGE; e++) begin : g_entry
    logic [ADDR_W-1:0] lo, hi;
    assign lo = starts[e*ADDR_W +: ADDR_W];
    assign hi = ends[e*ADDR_W +: ADDR_W];
    assign entry_hit[e] = valids[e] && (offset >= lo) && (offset <= hi);
  end

  assign hit = enable && (|entry_hit);
endmodule

// File: rtl/steer_id_derive.sv
module steer_id_derive #(
  parameter int NSLICE       = 4,
  parameter int SS_PER_SLICE = 4,
  parameter int L3_BANKS     = 8,
  parameter int GROUP_W      = 4,
  parameter int INST_W       = 4
) (
  input  logic [NSLICE*SS_PER_SLICE-1:0] ss_mask,
  input  logic [NSLICE-1:0]              slice_mem_en,
  input  logic [L3_BANKS-1:0]            l3_dis,
  output logic [GROUP_W-1:0]             l3_group,
  output logic [INST_W-1:0]              l3_inst,
  output logic                           l3_empty,
  output logic [GROUP_W-1:0]             ms_group,
  output logic                           ms_empty,
  output logic [GROUP_W-1:0]             lncf_group
);
  localparam int SL_IW = (NSLICE > 1) ? $clog2(NSLICE) : 1;
  localparam int L3_IW = (L3_BANKS > 1) ? $clog2(L3_BANKS) : 1;

  logic [NSLICE-1:0]   slice_mask;
  logic [L3_BANKS-1:0] l3_avail;
  logic [SL_IW-1:0]    slice_idx;
  logic [L3_IW-1:0]    bank_idx;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slice_mask[s] = (|ss_mask[s*SS_PER_SLICE +: SS_PER_SLICE]) | slice_mem_en[s];
  end

  assign l3_avail = ~l3_dis;

  steer_lowbit #(.W(NSLICE)) u_slice_low (
    .vec (slice_mask),
    .idx (slice_idx),
    .none(ms_empty)
  );

  steer_lowbit #(.W(L3_BANKS)) u_bank_low (
    .vec (l3_avail),
    .idx (bank_idx),
    .none(l3_empty)
  );

  assign l3_group   = '0;
  assign l3_inst    = l3_empty ? '0 : INST_W'(bank_idx);
  assign ms_group   = ms_empty ? '0 : GROUP_W'(slice_idx);
  assign lncf_group = ms_empty ? '0 : GROUP_W'(GROUP_W'(slice_idx) << 1);
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int NRANGE       = 12,
  parameter int NSLICE       = 4,
  parameter int SS_PER_SLICE = 4,
  parameter int L3_BANKS     = 8,
  parameter int GROUP_W      = 4,
  parameter int INST_W       = 4,
  localparam int TBL_W       = NCLASS * NRANGE * ADDR_W,
  localparam int CLS_TBL_W   = NRANGE * ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [ADDR_W-1:0]              in_offset,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [GROUP_W-1:0]             out_group,
  output logic [INST_W-1:0]              out_inst,
  output logic [2:0]                     out_class,
  output logic                           out_mask_empty,
  input  logic [NSLICE*SS_PER_SLICE-1:0] cfg_ss_mask,
  input  logic [NSLICE-1:0]              cfg_slice_mem_en,
  input  logic [L3_BANKS-1:0]            cfg_l3_dis,
  input  logic [3:0]                     cfg_class_en,
  input  logic [TBL_W-1:0]               cfg_tbl_start,
  input  logic [TBL_W-1:0]               cfg_tbl_end,
  input  logic [NCLASS*NRANGE-1:0]       cfg_tbl_valid,
  input  logic [GROUP_W-1:0]             cfg_dflt_group,
  input  logic [INST_W-1:0]              cfg_dflt_inst
);
  logic [NCLASS-1:0] cls_hit;

  for (genvar c = 0; c < NCLASS; c++) begin : g_class
    steer_range_match #(.ADDR_W(ADDR_W), .NRANGE(NRANGE)) u_match (
      .offset(in_offset),
      .starts(cfg_tbl_start[c*CLS_TBL_W +: CLS_TBL_W]),
      .ends  (cfg_tbl_end[c*CLS_TBL_W +: CLS_TBL_W]),
      .valids(cfg_tbl_valid[c*NRANGE +: NRANGE]),
      .enable(cfg_class_en[c]),
      .hit   (cls_hit[c])
    );
  end

  logic [GROUP_W-1:0] l3_group, ms_group, lncf_group;
  logic [INST_W-1:0]  l3_inst;
  logic               l3_empty, ms_empty;

  steer_id_derive #(
    .NSLICE(NSLICE), .SS_PER_SLICE(SS_PER_SLICE), .L3_BANKS(L3_BANKS),
    .GROUP_W(GROUP_W), .INST_W(INST_W)
  ) u_ids (
    .ss_mask     (cfg_ss_mask),
    .slice_mem_en(cfg_slice_mem_en),
    .l3_dis      (cfg_l3_dis),
    .l3_group    (l3_group),
    .l3_inst     (l3_inst),
    .l3_empty    (l3_empty),
    .ms_group    (ms_group),
    .ms_empty    (ms_empty),
    .lncf_group  (lncf_group)
  );

  // Fixed-priority pick: the lowest class code that hits wins.
  steer_class_e       win_cls;
  logic [GROUP_W-1:0] nxt_group;
  logic [INST_W-1:0]  nxt_inst;
  logic               nxt_empty;

  always_comb begin
    win_cls = CLS_DEFAULT;
    for (int c = NCLASS - 1; c >= 0; c--) begin
      if (cls_hit[c]) win_cls = steer_class_e'(CLS_W'(c));
    end
    nxt_group = cfg_dflt_group;
    nxt_inst  = cfg_dflt_inst;
    nxt_empty = 1'b0;
    unique case (win_cls)
      CLS_L3BANK: begin
        nxt_group = l3_group;
        nxt_inst  = l3_inst;
        nxt_empty = l3_empty;
      end
      CLS_MSLICE: begin
        nxt_group = ms_group;
        nxt_inst  = '0;
        nxt_empty = ms_empty;
      end
      CLS_LNCF: begin
        nxt_group = lncf_group;
        nxt_inst  = '0;
        nxt_empty = ms_empty;
      end
      CLS_INST0: begin
        nxt_group = '0;
        nxt_inst  = '0;
      end
      default: ;
    endcase
  end

  // Output register doubles as the single stream buffer.
  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_group      <= '0;
      out_inst       <= '0;
      out_class      <= '0;
      out_mask_empty <= 1'b0;
    end else if (accept) begin
      out_valid      <= 1'b1;
      out_group      <= nxt_group;
      out_inst       <= nxt_inst;
      out_class      <= win_cls;
      out_mask_empty <= nxt_empty;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_group) && $stable(out_inst)
                                && $stable(out_class) && $stable(out_mask_empty));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_zero_ids_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mask_empty |-> out_group == '0 && out_inst == '0);

  p_l3_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_L3BANK |-> out_group == '0);

  p_lncf_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_LNCF |-> out_group[0] == 1'b0 && out_inst == '0);

  p_inst0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_INST0 |-> out_group == '0 && out_inst == '0 && !out_mask_empty);

  p_class_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class <= 3'd4);
endmodule

// File: tb/test_steer_resolver.sv
module test_steer_resolver;
  localparam int AW = 24, NR = 12, NS = 4, SS = 4, LB = 8, GW = 4, IW = 4, NC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, out_mask_empty;
  logic [AW-1:0] in_offset = '0;
  logic [GW-1:0] out_group, dflt_g = '0;
  logic [IW-1:0] out_inst, dflt_i = '0;
  logic [2:0]    out_class;
  logic [NS*SS-1:0] ss_mask = '0;
  logic [NS-1:0]    mem_en = '0;
  logic [LB-1:0]    l3_dis = '0;
  logic [3:0]       cls_en = '0;
  logic [NC*NR*AW-1:0] f_start = '0, f_end = '0;
  logic [NC*NR-1:0]    f_valid = '0;

  logic [AW-1:0] t_start [NC][NR];
  logic [AW-1:0] t_end   [NC][NR];
  logic          t_vld   [NC][NR];

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  steer_resolver i_steer_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_offset(in_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_group(out_group), .out_inst(out_inst),
    .out_class(out_class), .out_mask_empty(out_mask_empty), .cfg_ss_mask(ss_mask),
    .cfg_slice_mem_en(mem_en), .cfg_l3_dis(l3_dis), .cfg_class_en(cls_en),
    .cfg_tbl_start(f_start), .cfg_tbl_end(f_end), .cfg_tbl_valid(f_valid),
    .cfg_dflt_group(dflt_g), .cfg_dflt_inst(dflt_i)
  );

  task automatic put(int c, int e, int lo, int hi, bit v);
    t_start[c][e] = AW'(lo);
    t_end[c][e]   = AW'(hi);
    t_vld[c][e]   = v;
  endtask

  task automatic pack();
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NR; e++) begin
        f_start[(c*NR+e)*AW +: AW] = t_start[c][e];
        f_end[(c*NR+e)*AW +: AW]   = t_end[c][e];
        f_valid[c*NR+e]            = t_vld[c][e];
      end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic [AW-1:0] off, output logic [2:0] cls,
                       output logic [GW-1:0] g, output logic [IW-1:0] i, output logic emp);
    int slow, blow;
    logic [NS-1:0] sm;
    cls = 3'd4; g = dflt_g; i = dflt_i; emp = 1'b0;
    for (int c = NC - 1; c >= 0; c--)
      if (cls_en[c])
        for (int e = 0; e < NR; e++)
          if (t_vld[c][e] && off >= t_start[c][e] && off <= t_end[c][e]) cls = 3'(c);
    for (int s = 0; s < NS; s++) sm[s] = (ss_mask[s*SS +: SS] != '0) || mem_en[s];
    slow = -1; blow = -1;
    for (int s = NS - 1; s >= 0; s--) if (sm[s]) slow = s;
    for (int b = LB - 1; b >= 0; b--) if (!l3_dis[b]) blow = b;
    case (cls)
      3'd0: begin g = 0; i = (blow < 0) ? 0 : IW'(blow); emp = (blow < 0); end
      3'd1: begin g = (slow < 0) ? 0 : GW'(slow); i = 0; emp = (slow < 0); end
      3'd2: begin g = (slow < 0) ? 0 : GW'(2*slow); i = 0; emp = (slow < 0); end
      3'd3: begin g = 0; i = 0; end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, logic [2:0] ec, logic [GW-1:0] eg, logic [IW-1:0] ei, logic ee);
    checks++;
    if (!(out_valid && out_class == ec && out_group == eg && out_inst == ei && out_mask_empty == ee)) begin
      fails++;
      $display("FAIL %s: got v=%0b cls=%0d g=%0d i=%0d e=%0b, exp v=1 cls=%0d g=%0d i=%0d e=%0b",
               tag, out_valid, out_class, out_group, out_inst, out_mask_empty, ec, eg, ei, ee);
    end
  endtask

  // One request; result sampled at the next falling edge (one register stage).
  task automatic req(logic [AW-1:0] off, string tag);
    logic [2:0] ec; logic [GW-1:0] eg; logic [IW-1:0] ei; logic ee;
    string t;
    @(negedge clk);
    in_valid = 1'b1; in_offset = off;
    @(negedge clk);
    in_valid = 1'b0;
    model(off, ec, eg, ei, ee);
    t = tag;
    if (t == "") begin
      case (ec)
        3'd0: t = "R4"; 3'd1: t = "R5"; 3'd2: t = "R6"; 3'd3: t = "R7"; default: t = "R8";
      endcase
      if (ee) t = "R10";
    end
    chk(t, ec, eg, ei, ee);
  endtask

  task automatic sweep();
    for (int off = 0; off < 1024; off++) req(AW'(off), "");
    req(24'hFFFFFF, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int e = 0; e < NR; e++) put(c, e, 0, 0, 1'b0);
    put(0, 0, 'h100, 'h13F, 1'b1);
    put(0, 5, 'h300, 'h30F, 1'b1);
    put(0, 11, 'h000, 'h3FF, 1'b0);   // invalid entry covers everything
    put(1, 0, 'h120, 'h1FF, 1'b1);
    put(1, 7, 'h380, 'h38F, 1'b1);
    put(2, 3, 'h1F0, 'h24F, 1'b1);
    put(3, 0, 'h240, 'h2FF, 1'b1);
    put(3, 11, 'h3F0, 'h3FF, 1'b1);
    pack();

    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12: out_valid=%0b in_ready=%0b, exp 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // Config A: slice 2 via sub-slices, lowest free bank 3.
    ss_mask = 16'h0F00; mem_en = 4'b0000; l3_dis = 8'b0000_0111;
    cls_en = 4'hF; dflt_g = 4'd5; dflt_i = 4'd9;
    req(24'h100, "R1"); req(24'h13F, "R1"); req(24'h0FF, "R1"); req(24'h140, "R1");
    req(24'h130, "R2"); req(24'h1F8, "R2"); req(24'h050, "R3");
    sweep();

    // Config B: slice from memory fuse only, no free bank, L3 table disabled.
    ss_mask = 16'h0000; mem_en = 4'b1000; l3_dis = 8'hFF; cls_en = 4'b1110;
    req(24'h130, "R3"); req(24'h150, "R9");
    sweep();
    cls_en = 4'hF;
    req(24'h100, "R10");

    // Config C: empty slice mask, bank 0 free, only classes 0 and 2 enabled.
    ss_mask = 16'h0000; mem_en = 4'b0000; l3_dis = 8'h00; cls_en = 4'b0101;
    dflt_g = 4'hF; dflt_i = 4'h0;
    req(24'h200, "R10");
    sweep();

    // R11: back-pressure holds the result and blocks new input.
    ss_mask = 16'h0010; mem_en = 4'b0000; l3_dis = 8'b0000_0001; cls_en = 4'hF;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_offset = 24'h100;
    @(negedge clk);
    in_offset = 24'h1A0;
    repeat (3) @(negedge clk);
    chk("R11", 3'd0, 4'd0, 4'd1, 1'b0);
    checks++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R11: in_ready=%0b during stall, exp 0", in_ready);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", 3'd1, 4'd1, 4'd0, 1'b0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11: out_valid=%0b after drain, exp 0", out_valid);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule